// File: doc/BRIEF.md
# Double-Buffered Colour Palette

This block turns 8-bit pixel indices into 24-bit RGB colours through a 256-entry palette held in two banks. At any moment one bank is live and feeds the pixel path. The other bank is the shadow, and every palette write from the register bus goes there. Software can therefore rebuild a complete palette while the display keeps reading a stable one.

When the new palette is ready, software flips a switch bit in the control word. The block does not change banks at once. It waits for the next frame-start pulse and then makes the requested bank live, so a frame is always drawn from a single bank. A read-only status bit shows which bank is live. When status equals the switch bit, the swap has finished and the shadow bank may be refilled.

Pixels enter as an index with a valid strobe. The colour appears on a registered output one clock later.

Top module: `palette_swap_lut`

## Requirements
- R1: After reset the switch bit and the status bit are 0, bank 0 is live, every entry of both banks is zero, `rgb_valid` is 0, `rgb_out` is 0 and `bus_rdata` is 0.
- R2: A bus write to byte address 4*k (k = 0..255, address bit 10 = 0, bits [1:0] = 0) stores the entry in the bank that is not live. A write never changes the colour the pixel path returns for the live bank.
- R3: An entry holds red in data bits [23:16], green in [15:8] and blue in [7:0]. Write data bits [31:24] are discarded, and a read returns them as 0. `rgb_out` uses the same packing.
- R4: The control word is at byte address 0x400. Bit 0 is the switch bit and is writable. Bit 1 is the status bit, and a write to it has no effect. A control read returns {30'b0, status, switch}.
- R5: The status bit copies the switch bit on the clock edge where `frame_start` is high, and at no other time.
- R6: `rgb_valid` is high exactly one cycle after a cycle with `pix_valid` high. At that point `rgb_out` is the live-bank entry at the index `pix_idx` held. `rgb_out` keeps its value while `pix_valid` is low.
- R7: A pixel presented in the same cycle as `frame_start` is looked up in the bank that was live before that edge.
- R8: `bus_rdata` carries the read result one cycle after `bus_rd`, and is 0 in any cycle after a cycle without `bus_rd`. A palette read returns the shadow-bank entry.
- R9: Writes to other addresses (bit 10 set with any address other than 0x400, or bits [1:0] not 0) change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_valid | input | 1 | Pixel index valid |
| pix_idx | input | 8 | Pixel index |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| rgb_valid | output | 1 | Colour valid, one cycle after `pix_valid` |
| rgb_out | output | 24 | Looked-up colour {R,G,B} |

## Verification
The live bank is not a port. If it is wrong, the fault shows up in two places:
- The next valid pixel returns a colour from the wrong bank, one cycle after its strobe.
- A control read returns the wrong status bit on the following cycle.

If the shadow bank is selected wrongly, live colours change mid-frame, or a palette read-back disagrees with what was written. The bench runs a behavioural two-bank model and compares both outputs on every clock. This catches such a fault at the first pixel or read that touches the affected entry.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAL  = 2'd1,
    ACC_CTRL = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/palette_decode.sv
module palette_decode #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0]      addr,
  output palette_pkg::acc_kind_e kind,
  output logic [IDX_W-1:0]       idx
);
  import palette_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(DEPTH * 4);

  always_comb begin
    idx  = addr[IDX_W+1:2];
    kind = ACC_NONE;
    if (addr[IDX_W+2] == 1'b0) begin
      if (addr[1:0] == 2'b00) kind = ACC_PAL;
    end else if (addr == CTRL_ADDR) begin
      kind = ACC_CTRL;
    end
  end
endmodule

// File: rtl/palette_ctrl.sv
module palette_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic ctrl_bit,
  input  logic frame_start,
  output logic sw_q,
  output logic live_q
);
  logic sw_d, live_d;

  always_comb begin
    sw_d   = sw_q;
    live_d = live_q;
    if (ctrl_we)     sw_d   = ctrl_bit;
    if (frame_start) live_d = sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      sw_q   <= sw_d;
      live_q <= live_d;
    end
  end

  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> live_q == $past(live_q));
  p_status_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> live_q == $past(sw_q));
endmodule

// File: rtl/palette_store.sv
module palette_store #(
  parameter int IDX_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          live_bank,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  palette_pkg::rgb_t             wr_data,
  input  logic [IDX_W-1:0]              bus_idx,
  input  logic [IDX_W-1:0]              pix_idx,
  output palette_pkg::rgb_t             shadow_rd,
  output palette_pkg::rgb_t             live_rd
);
  import palette_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam int NBANK = 2;

  rgb_t bank_pix [NBANK];
  rgb_t bank_bus [NBANK];
  logic shadow_bank;

  assign shadow_bank = ~live_bank;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rgb_t mem [DEPTH];
    logic bank_we;

    assign bank_we = wr_en && (shadow_bank == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (bank_we) begin
        mem[wr_idx] <= wr_data;
      end
    end

    assign bank_pix[b] = mem[pix_idx];
    assign bank_bus[b] = mem[bus_idx];
  end

  assign live_rd   = bank_pix[live_bank];
  assign shadow_rd = bank_bus[shadow_bank];
endmodule

// File: rtl/palette_swap_lut.sv
module palette_swap_lut #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 11,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              frame_start,
  output logic              rgb_valid,
  output logic [23:0]       rgb_out
);
  import palette_pkg::*;

  acc_kind_e        kind;
  logic [IDX_W-1:0] bus_idx;
  logic             sw_q, live_q;
  logic             pal_we, ctrl_we;
  rgb_t             shadow_rd, live_rd;
  rgb_t             rgb_q, rgb_d;
  logic             rgbv_q;
  logic [BUS_W-1:0] rdata_q, rdata_d;

  palette_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .kind(kind), .idx(bus_idx)
  );

  assign pal_we  = bus_wr && (kind == ACC_PAL);
  assign ctrl_we = bus_wr && (kind == ACC_CTRL);

  palette_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_bit(bus_wdata[0]),
    .frame_start(frame_start), .sw_q(sw_q), .live_q(live_q)
  );

  palette_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .live_bank(live_q), .wr_en(pal_we),
    .wr_idx(bus_idx), .wr_data(rgb_t'(bus_wdata[RGB_W-1:0])),
    .bus_idx(bus_idx), .pix_idx(pix_idx),
    .shadow_rd(shadow_rd), .live_rd(live_rd)
  );

  always_comb begin
    rgb_d   = pix_valid ? live_rd : rgb_q;
    rdata_d = '0;
    if (bus_rd) begin
      case (kind)
        ACC_PAL:  rdata_d = BUS_W'(shadow_rd);
        ACC_CTRL: rdata_d = BUS_W'({live_q, sw_q});
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q   <= '0;
      rgbv_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rgb_q   <= rgb_d;
      rgbv_q  <= pix_valid;
      rdata_q <= rdata_d;
    end
  end

  assign rgb_out   = rgb_q;
  assign rgb_valid = rgbv_q;
  assign bus_rdata = rdata_q;

  p_rgb_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid);
  p_rgb_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!rgb_valid && $stable(rgb_out)));
  p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
  p_ctrl_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && kind == ACC_CTRL) |=> bus_rdata[BUS_W-1:2] == '0);
  p_pal_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && kind == ACC_PAL) |=> bus_rdata[BUS_W-1:RGB_W] == '0);
endmodule

// File: tb/palette_swap_lut_tb.sv
module palette_swap_lut_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        frame_start = 1'b0;
  logic        rgb_valid;
  logic [23:0] rgb_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  palette_swap_lut u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .frame_start(frame_start),
    .rgb_valid(rgb_valid), .rgb_out(rgb_out)
  );

  // behavioural reference: two banks, switch, status
  logic [23:0] m [2][256];
  bit          msw, mst;
  logic        e_v;
  logic [23:0] e_rgb;
  logic [31:0] e_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) m[b][i] = '0;
      msw = 0; mst = 0; e_v = 0; e_rgb = '0; e_rd = '0;
    end else begin
      e_v = pix_valid;
      if (pix_valid) e_rgb = m[mst][pix_idx];
      e_rd = '0;
      if (bus_rd) begin
        if (!bus_addr[10] && bus_addr[1:0] == 2'b00) e_rd = {8'h00, m[~mst][bus_addr[9:2]]};
        else if (bus_addr == 11'h400) e_rd = {30'd0, mst, msw};
      end
      if (bus_wr) begin
        if (!bus_addr[10] && bus_addr[1:0] == 2'b00) m[~mst][bus_addr[9:2]] = bus_wdata[23:0];
        else if (bus_addr == 11'h400) msw = bus_wdata[0];
      end
      if (frame_start) mst = msw;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle model comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 rgb_valid", {31'd0, rgb_valid}, {31'd0, e_v});
      chk("R6 rgb_out", {8'd0, rgb_out}, {8'd0, e_rgb});
      chk("R8 bus_rdata", bus_rdata, e_rd);
    end
  end

  function automatic logic [23:0] colour(input int i);
    logic [7:0] k = 8'(i);
    return {k, ~k, k ^ 8'h5A};
  endfunction

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic px(input logic [7:0] i, input logic fs, output logic [23:0] c);
    @(negedge clk); pix_valid = 1; pix_idx = i; frame_start = fs;
    @(negedge clk); pix_valid = 0; frame_start = 0; c = rgb_out;
  endtask

  initial begin
    logic [31:0] d;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    chk("R1 rgb_valid reset", {31'd0, rgb_valid}, 32'd0);
    chk("R1 rgb_out reset", {8'd0, rgb_out}, 32'd0);
    rst_n = 1;
    rd(11'h400, d); chk("R1 control reset", d, 32'd0);
    rd(11'h010, d); chk("R1 entry reset", d, 32'd0);
    for (int i = 0; i < 256; i++) wr(11'(i * 4), {8'hAB, colour(i)});
    rd(11'h014, d); chk("R3 readback packing", d, {8'h00, colour(5)});
    px(8'd7, 0, c); chk("R2 live bank untouched", {8'd0, c}, 32'd0);
    wr(11'h400, 32'h3);
    rd(11'h400, d); chk("R4 status not writable", d, 32'h1);
    px(8'd7, 0, c); chk("R5 no swap without frame start", {8'd0, c}, 32'd0);
    px(8'd7, 1, c); chk("R7 old bank on swap edge", {8'd0, c}, 32'd0);
    px(8'd7, 0, c); chk("R6 new bank colour", {8'd0, c}, {8'd0, colour(7)});
    px(8'd200, 0, c); chk("R6 index 200", {8'd0, c}, {8'd0, colour(200)});
    rd(11'h400, d); chk("R5 status follows switch", d, 32'h3);
    wr(11'h01C, 32'hFF123456);
    px(8'd7, 0, c); chk("R2 shadow write hidden", {8'd0, c}, {8'd0, colour(7)});
    rd(11'h01C, d); chk("R8 shadow readback", d, 32'h00123456);
    wr(11'h404, 32'h0); wr(11'h01D, 32'h00ABCDEF);
    rd(11'h404, d); chk("R9 unmapped read", d, 32'd0);
    rd(11'h400, d); chk("R9 control unchanged", d, 32'h3);
    rd(11'h01C, d); chk("R9 misaligned write ignored", d, 32'h00123456);
    wr(11'h400, 32'h0);
    px(8'd7, 1, c); chk("R7 swap back edge", {8'd0, c}, {8'd0, colour(7)});
    px(8'd7, 0, c); chk("R2 refilled bank live", {8'd0, c}, 32'h00123456);
    px(8'd8, 0, c); chk("R6 untouched entry zero", {8'd0, c}, 32'd0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule